// File: doc/BRIEF.md
# Serial 1011 Pattern Lock

This block is a small lock controller that watches a one-bit serial stream and opens when the last four accepted bits read 1, 0, 1, 1, in order of arrival. It is a Moore machine with five states. Each state records how much of the pattern has been seen so far. The unlock flag comes only from the full-match state, so it never depends on the input bit in the same cycle.

Bits arrive on a valid/ready stream. A bit is consumed on a rising clock edge when valid and ready are both high. The block never applies back-pressure once it is out of reset. Ready is low only in the cycle that follows a reset edge. In every other cycle it is high, so an upstream source can hold valid and rely on one bit being consumed per cycle.

Matches may overlap. The tail of a full match counts as the start of the next one, so the stream 1011011 opens the lock twice. The current state code is also driven to a port, so the integrator can see how far the pattern has progressed.

Top module: `pat_lock`

## Requirements
- R1: Reset is synchronous and active high. After any clock edge at which rst is high, state_o is 0, unlock_o is 0 and in_ready_o is 0. This holds even if in_valid_i is high at that edge.
- R2: state_o encodes match progress as follows: 0 = nothing matched, 1 = "1" seen, 2 = "10" seen, 3 = "101" seen, 4 = full match. No other value ever appears.
- R3: unlock_o is high exactly while state_o is 4. It rises only on the edge that accepts a 1 while state_o is 3.
- R4: From state 0, an accepted 1 moves to state 1. An accepted 0 stays in state 0.
- R5: From state 1, an accepted 0 moves to state 2. An accepted 1 stays in state 1.
- R6: From state 2, an accepted 1 moves to state 3. An accepted 0 returns to state 0.
- R7: From state 3, an accepted 1 moves to state 4. An accepted 0 moves to state 2.
- R8: From state 4, an accepted 1 moves to state 1 and an accepted 0 moves to state 2. Unlock therefore lasts exactly one cycle when bits arrive back to back.
- R9: On an edge where in_valid_i or in_ready_o is low, the state holds and in_bit_i has no effect.
- R10: in_ready_o becomes 1 on the first edge with rst low and stays 1 until the next reset.
- R11: The back-to-back stream 1011011 gives two one-cycle unlock pulses, after the fourth and after the seventh accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bit_i | input | 1 | Serial data bit |
| in_valid_i | input | 1 | Data bit is valid this cycle |
| in_ready_o | output | 1 | Block accepts a bit this cycle |
| unlock_o | output | 1 | Full pattern matched (Moore) |
| state_o | output | 3 | Current state code |

## Verification
The hardest case to reach is reset arriving while the machine sits in the full-match state and a valid 1 is presented in the same cycle. Without reset, that bit would move the machine to state 1 and drop unlock. To reach this case, the stimulus first drives the complete pattern, then raises reset and valid together with a 1 on the data bit. The checks confirm that reset wins and that the bit is lost. Hold behaviour is exercised by parking the machine in state 3 with a 1 on the data line while valid is low. A single wrongly accepted bit there would open the lock.

// File: rtl/pat_lock_pkg.sv
package pat_lock_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    LK_NONE  = 3'd0,
    LK_ONE   = 3'd1,
    LK_OZ    = 3'd2,
    LK_OZO   = 3'd3,
    LK_FULL  = 3'd4
  } lk_state_e;
endpackage

// File: rtl/pat_lock_next.sv
module pat_lock_next
  import pat_lock_pkg::*;
(
  input  lk_state_e cur_i,
  input  logic      take_i,
  input  logic      bit_i,
  output lk_state_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (take_i) begin
      unique case (cur_i)
        LK_NONE: nxt_o = bit_i ? LK_ONE : LK_NONE;
        LK_ONE:  nxt_o = bit_i ? LK_ONE : LK_OZ;
        LK_OZ:   nxt_o = bit_i ? LK_OZO : LK_NONE;
        LK_OZO:  nxt_o = bit_i ? LK_FULL : LK_OZ;
        LK_FULL: nxt_o = bit_i ? LK_ONE : LK_OZ;
        default: nxt_o = LK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pat_lock_reg.sv
module pat_lock_reg
  import pat_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lk_state_e nxt_i,
  output lk_state_e cur_o,
  output logic      ready_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o   <= LK_NONE;
      ready_o <= 1'b0;
    end else begin
      cur_o   <= nxt_i;
      ready_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pat_lock_out.sv
module pat_lock_out
  import pat_lock_pkg::*;
(
  input  lk_state_e cur_i,
  output logic      unlock_o,
  output logic [STATE_W-1:0] code_o
);
  always_comb begin
    unlock_o = (cur_i == LK_FULL);
    code_o   = cur_i;
  end
endmodule

// File: rtl/pat_lock.sv
module pat_lock
  import pat_lock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_bit_i,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic unlock_o,
  output logic [2:0] state_o
);
  lk_state_e cur;
  lk_state_e nxt;
  logic      take;

  assign take = in_valid_i & in_ready_o;

  pat_lock_next u_next (
    .cur_i (cur),
    .take_i(take),
    .bit_i (in_bit_i),
    .nxt_o (nxt)
  );

  pat_lock_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .nxt_i  (nxt),
    .cur_o  (cur),
    .ready_o(in_ready_o)
  );

  pat_lock_out u_out (
    .cur_i   (cur),
    .unlock_o(unlock_o),
    .code_o  (state_o)
  );
endmodule

// File: rtl/pat_lock_chk.sv
module pat_lock_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_bit_i,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic       unlock_o,
  input logic [2:0] state_o
);
  logic acc;
  assign acc = in_valid_i & in_ready_o;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (state_o == 3'd0 && !unlock_o && !in_ready_o));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd4);

  // R3
  unlock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock_o) |-> ($past(state_o) == 3'd3 && $past(in_bit_i) && $past(acc)));

  // R5
  one_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && acc && in_bit_i) |=> state_o == 3'd1);

  // R8
  unlock_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (unlock_o && acc) |=> !unlock_o);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(state_o));

  // R10
  ready_stays_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready_o |=> in_ready_o);
endmodule

bind pat_lock pat_lock_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_bit_i  (in_bit_i),
  .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o),
  .unlock_o  (unlock_o),
  .state_o   (state_o)
);

// File: tb/pat_lock_bench.sv
`timescale 1ns/1ps
module pat_lock_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit_i = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic unlock_o;
  logic [2:0] state_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pat_lock u_pat_lock (
    .clk       (clk),
    .rst       (rst),
    .in_bit_i  (in_bit_i),
    .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o),
    .unlock_o  (unlock_o),
    .state_o   (state_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int exp_st);
    chk(state_o == exp_st[2:0], req, state_o, exp_st);
    chk(unlock_o == (exp_st == 4), {req, " unlock"}, unlock_o, (exp_st == 4));
  endtask

  task automatic send(input bit b);
    @(negedge clk);
    in_bit_i = b;
    in_valid_i = 1'b1;
    @(posedge clk);
    #1;
    in_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(state_o == 3'd0, "R1 state", state_o, 0);
    chk(!unlock_o, "R1 unlock", unlock_o, 0);
    chk(!in_ready_o, "R1 ready", in_ready_o, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk(in_ready_o, "R10 ready", in_ready_o, 1);
  endtask

  task automatic t_overlap();
    bit seq [7] = '{1, 0, 1, 1, 0, 1, 1};
    int exp [7] = '{1, 2, 3, 4, 2, 3, 4};
    do_reset();
    for (int i = 0; i < 7; i++) begin
      send(seq[i]);
      chk_state("R11 R7 stream", exp[i]);
    end
  endtask

  task automatic t_edges();
    do_reset();
    send(0); chk_state("R4 zero stays", 0);
    send(1); chk_state("R4 one", 1);
    send(1); chk_state("R5 one repeat", 1);
    send(0); chk_state("R5 zero", 2);
    send(0); chk_state("R6 zero back", 0);
    send(1); send(0); send(1); chk_state("R6 one", 3);
    send(0); chk_state("R7 zero", 2);
    send(1); send(1); chk_state("R3 full", 4);
    send(1); chk_state("R8 one", 1);
    send(0); send(1); send(1); send(0); chk_state("R8 zero", 2);
  endtask

  task automatic t_hold();
    do_reset();
    send(1); send(0); send(1);
    @(negedge clk);
    in_bit_i = 1'b1;
    in_valid_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      #1;
      chk_state("R9 hold", 3);
    end
    send(1); chk_state("R3 after hold", 4);
    @(posedge clk); #1;
    chk_state("R9 full hold", 4);
  endtask

  task automatic t_reset_race();
    do_reset();
    send(1); send(0); send(1); send(1);
    chk_state("R2 full code", 4);
    @(negedge clk);
    rst = 1'b1;
    in_bit_i = 1'b1;
    in_valid_i = 1'b1;
    @(posedge clk);
    #1;
    chk_state("R1 reset beats bit", 0);
    chk(!in_ready_o, "R1 ready low", in_ready_o, 0);
    @(negedge clk);
    rst = 1'b0;
    in_valid_i = 1'b0;
    @(posedge clk);
    #1;
    chk_state("R1 after release", 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_overlap();
    t_edges();
    t_hold();
    t_reset_race();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule